// File: doc/BRIEF.md
# Saturating Interval Capture Counter

This block measures the spacing between trigger events on a shared timebase. A counter steps up by one for every rate pulse, a one-cycle enable produced elsewhere from a pre-processed clock. When either of two trigger inputs fires, the block keeps the count reached so far and restarts counting from zero. In the same step it raises a one-cycle transmit shift event, which lets a downstream shifter start a frame for each measured interval.

The counter stops at its all-ones value instead of wrapping. A very long gap therefore reads as full scale and never as a short count. One enable input gates the whole function. While it is low, the counter is held at zero and the triggers have no effect.

Top module: `interval_capture_counter`

## Requirements
- R1: After reset, `cap_value` is 0 and both `cap_valid` and `shift_evt` are low.
- R2: While `meas_en` is high, the counter rises by exactly one in each cycle in which `rate_tick` is high. A capture taken after N rate pulses reports N.
- R3: The counter stops at 2^CNT_W-1 (1023 with the default width of 10) and does not wrap, however many further rate pulses arrive.
- R4: Each cycle in which `meas_en` is high and `trig_a` or `trig_b` is high counts as one trigger. The count held at that edge is loaded into `cap_value`, and `cap_valid` is high in the following cycle.
- R5: A trigger clears the counter to 0, so the next capture reports only the rate pulses that came after it.
- R6: For every trigger, `shift_evt` is high for exactly one cycle, in the same cycle as `cap_valid`. Neither output is ever high for two cycles from one trigger.
- R7: While `meas_en` is low, triggers are ignored: `cap_valid` and `shift_evt` stay low and `cap_value` keeps its last value.
- R8: While `meas_en` is low, the counter is held at 0. A trigger in the first cycle after re-enabling captures 0.
- R9: When a trigger and a rate pulse fall in the same cycle, the capture takes the count before that pulse and the counter restarts at 0.
- R10: Triggers on both inputs in the same cycle give a single capture and a single one-cycle shift event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_tick | input | 1 | Counting rate pulse, one cycle per step |
| trig_a | input | 1 | First trigger pulse |
| trig_b | input | 1 | Second trigger pulse |
| meas_en | input | 1 | Measurement enable; resets to low |
| cap_value | output | CNT_W | Last captured count |
| cap_valid | output | 1 | One-cycle strobe: `cap_value` was just loaded |
| shift_evt | output | 1 | One-cycle transmit shift event |

## Verification
Captures are taken after short bursts of different lengths on each trigger input in turn, which shows that the counter steps once per pulse and restarts on every capture. A burst longer than the counter range shows saturation rather than wrap. A trigger coinciding with a rate pulse, and a trigger on both inputs at once, show the pre-increment capture rule and the merge into a single event. Triggers and pulses applied with the enable low, followed by an immediate capture after re-enabling, show that the inputs are ignored and that the counter is held at zero.

// File: rtl/interval_capture_counter.sv
module interval_capture_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_tick,
  input  logic             trig_a,
  input  logic             trig_b,
  input  logic             meas_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_valid,
  output logic             shift_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic             fire;
  logic             at_max;

  assign fire   = meas_en & (trig_a | trig_b);
  assign at_max = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (!meas_en || fire)
      count <= '0;
    else if (rate_tick && !at_max)
      count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cap_value <= '0;
    else if (fire)
      cap_value <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      shift_evt <= 1'b0;
    end else begin
      cap_valid <= fire;
      shift_evt <= fire;
    end
  end

endmodule

// File: rtl/interval_capture_counter_chk.sv
module interval_capture_counter_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_tick,
  input logic             trig_a,
  input logic             trig_b,
  input logic             meas_en,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_valid,
  input logic             shift_evt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid == shift_evt); // R6

  AST_TRIG_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && (trig_a || trig_b)) |=> (cap_valid && cap_value == $past(count))); // R4

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_en && (trig_a || trig_b)) |=> !cap_valid); // R6

  AST_IDLE_HOLDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_en && (trig_a || trig_b)) |=> $stable(cap_value)); // R7

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && (trig_a || trig_b)) |=> count == '0); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && !trig_a && !trig_b && count == TOP) |=> count == TOP); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && !trig_a && !trig_b && rate_tick && count != TOP) |=> count == $past(count) + 1'b1); // R2

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> count == '0); // R8

endmodule

bind interval_capture_counter interval_capture_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .trig_a(trig_a), .trig_b(trig_b),
  .meas_en(meas_en), .count(count), .cap_value(cap_value), .cap_valid(cap_valid),
  .shift_evt(shift_evt)
);

// File: tb/interval_capture_counter_test.sv
module interval_capture_counter_test;

  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_tick = 1'b0, trig_a = 1'b0, trig_b = 1'b0, meas_en = 1'b0;
  logic [W-1:0] cap_value;
  logic cap_valid, shift_evt;

  int total = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  interval_capture_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .trig_a(trig_a), .trig_b(trig_b),
    .meas_en(meas_en), .cap_value(cap_value), .cap_valid(cap_valid), .shift_evt(shift_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rate_tick = 1'b1;
    end
    @(negedge clk); rate_tick = 1'b0;
  endtask

  // drive one trigger cycle, then check the strobe cycle and the cycle after
  task automatic fire(input logic a, input logic b, input logic t,
                      input logic exp_v, input int exp_val, input string req);
    @(negedge clk); trig_a = a; trig_b = b; rate_tick = t;
    @(negedge clk); trig_a = 1'b0; trig_b = 1'b0; rate_tick = 1'b0;
    chk({req, " cap_valid"}, cap_valid, exp_v);
    chk({req, " shift_evt"}, shift_evt, exp_v);
    chk({req, " cap_value"}, cap_value, exp_val);
    @(negedge clk);
    chk({req, " cap_valid one wide (R6)"}, cap_valid, 0);
    chk({req, " shift_evt one wide (R6)"}, shift_evt, 0);
  endtask

  task automatic t_reset;
    chk("R1 cap_value", cap_value, 0);
    chk("R1 cap_valid", cap_valid, 0);
    chk("R1 shift_evt", shift_evt, 0);
  endtask

  task automatic t_count_and_clear;
    ticks(5);
    fire(1, 0, 0, 1, 5, "R2 R4 trig_a after 5");
    ticks(7);
    fire(0, 1, 0, 1, 7, "R5 trig_b after 7");
    fire(1, 0, 0, 1, 0, "R5 back to back");
  endtask

  task automatic t_saturate;
    ticks(1100);
    fire(0, 1, 0, 1, 1023, "R3 saturation");
  endtask

  task automatic t_same_cycle;
    ticks(3);
    fire(1, 0, 1, 1, 3, "R9 trig with tick");
    fire(1, 0, 0, 1, 0, "R9 restart at 0");
  endtask

  task automatic t_both;
    ticks(4);
    fire(1, 1, 0, 1, 4, "R10 both triggers");
    fire(0, 1, 0, 1, 0, "R10 single clear");
  endtask

  task automatic t_disabled;
    ticks(9);
    fire(1, 0, 0, 1, 9, "R7 setup");
    @(negedge clk); meas_en = 1'b0;
    ticks(10);
    fire(1, 1, 1, 0, 9, "R7 disabled trig ignored");
    @(negedge clk); meas_en = 1'b1;
    fire(1, 0, 0, 1, 0, "R8 counter held at 0");
    ticks(6);
    @(negedge clk); meas_en = 1'b0;
    @(negedge clk); meas_en = 1'b1;
    fire(0, 1, 0, 1, 0, "R8 disable clears count");
  endtask

  initial begin
    #1000000;
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); meas_en = 1'b1;
    t_count_and_clear();
    t_saturate();
    t_same_cycle();
    t_both();
    t_disabled();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule